// File: doc/BRIEF.md
# Synchronous Burst Read Engine

This block is the read side of a synchronous static memory that serves four-word bursts. On a clock edge where either address strobe is low and all three chip enables are in their active state, it latches the external address as the start of a burst. Each later edge with the advance input low and no strobe moves a short burst counter one step. The counter wraps inside an aligned group of four words, so after four beats the burst returns to the word it started on. Holding advance high freezes the burst. A strobe seen while the chip is not selected ends the burst, and the data output floats.

The stored words come from a fixed arithmetic pattern, so the block acts as a read-only array. Read data passes through one output register. The output driver is enabled from registered copies of the output-enable and write-control inputs, so a change on those pins takes effect only after a clock edge.

Top module: `burst_sram_reader`

## Requirements
- R1: The chip counts as selected only when `ce_n` is 0, `ce2_n` is 0 and `ce2` is 1. Every other combination of these three inputs is unselected.
- R2: On an edge where `adsp_n` or `adsc_n` (or both) is 0 and the chip is selected, address A is latched. After the next edge, `dout` holds the word of A.
- R3: On each edge with no strobe and `adv_n` at 0 during an active burst, the burst advances. Beat n reads the address whose upper bits equal those of A and whose two low bits equal (A[1:0] + n) mod 4.
- R4: After four beats the burst returns to A and keeps cycling through the same four words.
- R5: On an edge with no strobe and `adv_n` at 1, the burst position holds, and the same word is presented again after the next edge.
- R6: A selected strobe during a burst abandons that burst and starts a new one at the new address.
- R7: A strobe while unselected ends the burst. `dout_drive` is 0 from the second edge after it, and stays 0 until a later selected strobe has been followed by two edges.
- R8: `dout_drive` is 1 only when a burst word is held in the output register and `oe_n` was 0 at the previous edge. A change on `oe_n` between edges does not affect `dout_drive` until the next edge.
- R9: While `rst` is 1, `dout_drive` and `dout` are 0, and the chip is treated as unselected.
- R10: The word stored at address a is (a*97 + 13) mod 2^DATA_W.
- R11: If `gw_n` is 0, or any bit of `bw_n` is 0, at an edge, `dout_drive` is 0 after that edge. No stored word ever changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| addr | input | ADDR_W | External burst start address |
| ce_n | input | 1 | Primary chip enable, active low |
| ce2_n | input | 1 | Second chip enable, active low |
| ce2 | input | 1 | Third chip enable, active high |
| adsp_n | input | 1 | First address strobe, active low |
| adsc_n | input | 1 | Second address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| oe_n | input | 1 | Output enable, active low, takes effect after an edge |
| gw_n | input | 1 | Global write control, active low; blocks the driver |
| bw_n | input | DATA_W/8 | Byte write controls, active low; block the driver |
| dout | output | DATA_W | Registered read data |
| dout_drive | output | 1 | Tri-state driver enable for `dout` |

## Verification
The properties look back up to two edges. They assume that every input is a known level that changes only between rising edges, and that reset is held for at least two edges. The bench changes all inputs on the falling clock edge and keeps reset asserted for several cycles, so these assumptions hold throughout. In the random phase most cycles select the chip and strobes are infrequent, so long bursts, suspends, wraps and deselects all occur. Directed sequences add every unselected enable pattern, an offset start address that wraps inside its group, and toggles of the output-enable and write-control pins.

// File: rtl/burst_sram_pkg.sv
package burst_sram_pkg;

   typedef enum logic [1:0] {
      CMD_HOLD  = 2'd0,
      CMD_STEP  = 2'd1,
      CMD_LOAD  = 2'd2,
      CMD_DESEL = 2'd3
   } burst_cmd_e;

   function automatic logic [31:0] cell_word(input int unsigned a,
                                             input int unsigned mult,
                                             input int unsigned add);
      return 32'(a * mult + add);
   endfunction

endpackage

// File: rtl/burst_cmd_decode.sv
module burst_cmd_decode
   import burst_sram_pkg::*;
(
   input  logic       ce_n,
   input  logic       ce2_n,
   input  logic       ce2,
   input  logic       adsp_n,
   input  logic       adsc_n,
   input  logic       adv_n,
   input  logic       active,
   output burst_cmd_e cmd
);
   logic sel;
   logic strobe;

   assign sel    = !ce_n && !ce2_n && ce2;
   assign strobe = !adsp_n || !adsc_n;

   always_comb begin
      if (strobe)
         cmd = sel ? CMD_LOAD : CMD_DESEL;
      else if (active && !adv_n)
         cmd = CMD_STEP;
      else
         cmd = CMD_HOLD;
   end
endmodule

// File: rtl/burst_addr_ctl.sv
module burst_addr_ctl
   import burst_sram_pkg::*;
#(
   parameter int ADDR_W  = 8,
   parameter int BURST_W = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  burst_cmd_e        cmd,
   input  logic [ADDR_W-1:0] addr,
   output logic [ADDR_W-1:0] rd_addr,
   output logic              active,
   output logic [BURST_W-1:0] cnt
);
   localparam int HI_W = ADDR_W - BURST_W;

   logic [ADDR_W-1:0]  base_q;
   logic [BURST_W-1:0] cnt_q;
   logic               act_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         base_q <= '0;
         cnt_q  <= '0;
         act_q  <= 1'b0;
      end else begin
         case (cmd)
            CMD_LOAD: begin
               base_q <= addr;
               cnt_q  <= '0;
               act_q  <= 1'b1;
            end
            CMD_DESEL: begin
               cnt_q <= '0;
               act_q <= 1'b0;
            end
            CMD_STEP: cnt_q <= cnt_q + 1'b1;
            default: ;
         endcase
      end
   end

   logic [BURST_W-1:0] low_sum;
   logic [HI_W-1:0]    hi_part;
   assign low_sum = base_q[BURST_W-1:0] + cnt_q;
   assign hi_part = base_q[ADDR_W-1:BURST_W];
   assign rd_addr = {hi_part, low_sum};
   assign active  = act_q;
   assign cnt     = cnt_q;
endmodule

// File: rtl/burst_cell_array.sv
module burst_cell_array
   import burst_sram_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 16,
   parameter int MULT   = 97,
   parameter int ADD    = 13
) (
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data
);
   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] cells [DEPTH];

   for (genvar i = 0; i < DEPTH; i++) begin : g_cell
      assign cells[i] = DATA_W'(cell_word(i, MULT, ADD));
   end

   assign rd_data = cells[rd_addr];
endmodule

// File: rtl/burst_out_stage.sv
module burst_out_stage #(
   parameter int DATA_W = 16,
   parameter int BYTES  = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              active,
   input  logic [DATA_W-1:0] rd_data,
   input  logic              oe_n,
   input  logic              gw_n,
   input  logic [BYTES-1:0]  bw_n,
   output logic [DATA_W-1:0] dout,
   output logic              dout_drive
);
   logic [DATA_W-1:0] data_q;
   logic              valid_q;
   logic              en_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         data_q  <= '0;
         valid_q <= 1'b0;
         en_q    <= 1'b0;
      end else begin
         if (active)
            data_q <= rd_data;
         valid_q <= active;
         en_q    <= !oe_n && gw_n && (&bw_n);
      end
   end

   assign dout       = data_q;
   assign dout_drive = valid_q && en_q;
endmodule

// File: rtl/burst_sram_reader.sv
module burst_sram_reader
   import burst_sram_pkg::*;
#(
   parameter int ADDR_W  = 8,
   parameter int DATA_W  = 16,
   parameter int BURST_W = 2,
   parameter int MULT    = 97,
   parameter int ADD     = 13,
   localparam int BYTES  = DATA_W / 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [ADDR_W-1:0] addr,
   input  logic              ce_n,
   input  logic              ce2_n,
   input  logic              ce2,
   input  logic              adsp_n,
   input  logic              adsc_n,
   input  logic              adv_n,
   input  logic              oe_n,
   input  logic              gw_n,
   input  logic [BYTES-1:0]  bw_n,
   output logic [DATA_W-1:0] dout,
   output logic              dout_drive
);
   if (BURST_W < 1 || BURST_W >= ADDR_W) begin : g_bad_burst
      $error("BURST_W must be at least 1 and below ADDR_W");
   end
   if (DATA_W < 8 || (DATA_W % 8) != 0) begin : g_bad_data
      $error("DATA_W must be a positive multiple of 8");
   end

   burst_cmd_e          cmd;
   logic                act_q;
   logic [BURST_W-1:0]  cnt_q;
   logic [ADDR_W-1:0]   rd_addr;
   logic [DATA_W-1:0]   rd_data;

   burst_cmd_decode u_dec (
      .ce_n   (ce_n),
      .ce2_n  (ce2_n),
      .ce2    (ce2),
      .adsp_n (adsp_n),
      .adsc_n (adsc_n),
      .adv_n  (adv_n),
      .active (act_q),
      .cmd    (cmd)
   );

   burst_addr_ctl #(.ADDR_W(ADDR_W), .BURST_W(BURST_W)) u_addr (
      .clk     (clk),
      .rst     (rst),
      .cmd     (cmd),
      .addr    (addr),
      .rd_addr (rd_addr),
      .active  (act_q),
      .cnt     (cnt_q)
   );

   burst_cell_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W),
                      .MULT(MULT), .ADD(ADD)) u_cells (
      .rd_addr (rd_addr),
      .rd_data (rd_data)
   );

   burst_out_stage #(.DATA_W(DATA_W), .BYTES(BYTES)) u_out (
      .clk        (clk),
      .rst        (rst),
      .active     (act_q),
      .rd_data    (rd_data),
      .oe_n       (oe_n),
      .gw_n       (gw_n),
      .bw_n       (bw_n),
      .dout       (dout),
      .dout_drive (dout_drive)
   );
endmodule

// File: rtl/burst_sram_reader_chk.sv
module burst_sram_reader_chk #(
   parameter int BURST_W = 2,
   parameter int DATA_W  = 16,
   parameter int BYTES   = 2
) (
   input logic               clk,
   input logic               rst,
   input logic               ce_n,
   input logic               ce2_n,
   input logic               ce2,
   input logic               adsp_n,
   input logic               adsc_n,
   input logic               adv_n,
   input logic               oe_n,
   input logic               gw_n,
   input logic [BYTES-1:0]   bw_n,
   input logic [DATA_W-1:0]  dout,
   input logic               dout_drive,
   input logic               act_q,
   input logic [BURST_W-1:0] cnt_q
);
   logic sel, strobe;
   assign sel    = !ce_n && !ce2_n && ce2;
   assign strobe = !adsp_n || !adsc_n;

   // R2
   read_starts_chk: assert property (@(posedge clk) disable iff (rst)
      ($past(strobe && sel, 2) && !$past(strobe && !sel) && $past(!oe_n)
       && $past(gw_n && (&bw_n))) |-> dout_drive);

   // R7
   desel_float_chk: assert property (@(posedge clk) disable iff (rst)
      $past(strobe && !sel, 2) |-> !dout_drive);

   // R8
   oe_after_edge_chk: assert property (@(posedge clk) disable iff (rst)
      $past(oe_n) |-> !dout_drive);

   // R11
   write_blocks_chk: assert property (@(posedge clk) disable iff (rst)
      $past(!gw_n || !(&bw_n)) |-> !dout_drive);

   // R5
   suspend_hold_chk: assert property (@(posedge clk) disable iff (rst)
      $past(!strobe && adv_n && act_q, 2) |-> $stable(dout));

   // R4
   wrap_group_chk: assert property (@(posedge clk) disable iff (rst)
      (act_q && !strobe && !adv_n && (&cnt_q)) |=> (cnt_q == '0));

   // R9
   reset_quiet_chk: assert property (@(posedge clk)
      $past(rst) |-> (!dout_drive && !act_q));
endmodule

bind burst_sram_reader burst_sram_reader_chk #(
   .BURST_W(BURST_W), .DATA_W(DATA_W), .BYTES(BYTES)
) u_chk (
   .clk        (clk),
   .rst        (rst),
   .ce_n       (ce_n),
   .ce2_n      (ce2_n),
   .ce2        (ce2),
   .adsp_n     (adsp_n),
   .adsc_n     (adsc_n),
   .adv_n      (adv_n),
   .oe_n       (oe_n),
   .gw_n       (gw_n),
   .bw_n       (bw_n),
   .dout       (dout),
   .dout_drive (dout_drive),
   .act_q      (act_q),
   .cnt_q      (cnt_q)
);

// File: tb/burst_sram_reader_test.sv
module burst_sram_reader_test;
   localparam int AW = 8;
   localparam int DW = 16;
   localparam int NB = DW / 8;
   localparam int MULT = 97;
   localparam int ADD  = 13;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic [AW-1:0] addr = '0;
   logic          ce_n = 1'b1, ce2_n = 1'b1, ce2 = 1'b0;
   logic          adsp_n = 1'b1, adsc_n = 1'b1, adv_n = 1'b1, oe_n = 1'b1;
   logic          gw_n = 1'b1;
   logic [NB-1:0] bw_n = '1;
   logic [DW-1:0] dout;
   logic          dout_drive;

   int total = 0;
   int bad   = 0;
   string cur_tag = "R2";

   always #4 clk = ~clk;

   burst_sram_reader uut (
      .clk(clk), .rst(rst), .addr(addr), .ce_n(ce_n), .ce2_n(ce2_n),
      .ce2(ce2), .adsp_n(adsp_n), .adsc_n(adsc_n), .adv_n(adv_n),
      .oe_n(oe_n), .gw_n(gw_n), .bw_n(bw_n), .dout(dout),
      .dout_drive(dout_drive)
   );

   // R10: stored word pattern
   function automatic logic [DW-1:0] exp_word(input int a);
      return DW'(a * MULT + ADD);
   endfunction

   // reference model state
   logic          m_act = 1'b0;
   logic [AW-1:0] m_base = '0;
   logic [1:0]    m_cnt = '0;
   logic [DW-1:0] m_dout = '0;
   logic          m_valid = 1'b0;
   logic          m_en = 1'b0;

   function automatic logic [AW-1:0] m_addr(input logic [AW-1:0] b,
                                            input logic [1:0] c);
      logic [1:0] lo;
      lo = b[1:0] + c;
      return {b[AW-1:2], lo};
   endfunction

   always @(posedge clk) begin
      if (rst) begin
         m_act <= 1'b0; m_cnt <= '0; m_base <= '0;
         m_dout <= '0; m_valid <= 1'b0; m_en <= 1'b0;
      end else begin
         if (m_act) m_dout <= exp_word(int'(m_addr(m_base, m_cnt)));
         m_valid <= m_act;
         m_en    <= !oe_n && gw_n && (&bw_n);
         if (!adsp_n || !adsc_n) begin
            if (!ce_n && !ce2_n && ce2) begin
               m_act <= 1'b1; m_base <= addr; m_cnt <= '0;
            end else begin
               m_act <= 1'b0; m_cnt <= '0;
            end
         end else if (m_act && !adv_n) begin
            m_cnt <= m_cnt + 2'd1;
         end
      end
   end

   task automatic check(input string tag, input logic [31:0] act,
                        input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   always @(posedge clk) begin
      #2;
      if (rst) begin
         check("R9", {31'd0, dout_drive}, 32'd0);
         check("R9", {16'd0, dout}, 32'd0);
      end else begin
         check(cur_tag == "R10" ? "R8" : cur_tag,
               {31'd0, dout_drive}, {31'd0, m_valid && m_en});
         if (m_valid && m_en)
            check(cur_tag, {16'd0, dout}, {16'd0, m_dout});
      end
   end

   // ce = {ce_n, ce2_n, ce2}; 3'b001 selects (R1)
   task automatic drv(input logic [AW-1:0] a, input logic [2:0] ce,
                      input logic sp, input logic sc, input logic adv,
                      input logic oe);
      @(negedge clk);
      addr = a; {ce_n, ce2_n, ce2} = ce;
      adsp_n = sp; adsc_n = sc; adv_n = adv; oe_n = oe;
   endtask

   initial begin
      void'($urandom(32'h5eed_0b57));
      repeat (4) @(negedge clk);
      rst = 1'b0;

      // R2: single read through either strobe
      cur_tag = "R2";
      drv(8'h21, 3'b001, 1'b1, 1'b0, 1'b1, 1'b0);
      drv(8'h00, 3'b110, 1'b1, 1'b1, 1'b1, 1'b0);
      drv(8'h00, 3'b110, 1'b1, 1'b1, 1'b1, 1'b0);
      drv(8'h37, 3'b001, 1'b0, 1'b0, 1'b1, 1'b0);
      drv(8'h00, 3'b001, 1'b1, 1'b1, 1'b1, 1'b0);
      drv(8'h00, 3'b001, 1'b1, 1'b1, 1'b1, 1'b0);

      // R3 R4: offset start wraps inside its group, cycled twice
      cur_tag = "R3";
      drv(8'h4E, 3'b001, 1'b0, 1'b1, 1'b1, 1'b0);
      for (int i = 0; i < 4; i++) drv(8'h00, 3'b001, 1'b1, 1'b1, 1'b0, 1'b0);
      cur_tag = "R4";
      for (int i = 0; i < 5; i++) drv(8'h00, 3'b001, 1'b1, 1'b1, 1'b0, 1'b0);

      // R5: suspend in mid burst
      cur_tag = "R5";
      drv(8'h91, 3'b001, 1'b1, 1'b0, 1'b1, 1'b0);
      drv(8'h00, 3'b001, 1'b1, 1'b1, 1'b0, 1'b0);
      for (int i = 0; i < 4; i++) drv(8'h00, 3'b001, 1'b1, 1'b1, 1'b1, 1'b0);
      drv(8'h00, 3'b001, 1'b1, 1'b1, 1'b0, 1'b0);
      drv(8'h00, 3'b001, 1'b1, 1'b1, 1'b0, 1'b0);

      // R6: new strobe aborts burst
      cur_tag = "R6";
      drv(8'hC3, 3'b001, 1'b0, 1'b1, 1'b0, 1'b0);
      drv(8'h00, 3'b001, 1'b1, 1'b1, 1'b0, 1'b0);
      drv(8'h16, 3'b001, 1'b1, 1'b0, 1'b0, 1'b0);
      drv(8'h00, 3'b001, 1'b1, 1'b1, 1'b0, 1'b0);
      drv(8'h00, 3'b001, 1'b1, 1'b1, 1'b0, 1'b0);

      // R1 R7: every unselected enable pattern deselects
      for (int p = 0; p < 8; p++) begin
         if (p == 1) continue;
         cur_tag = "R1";
         drv(8'h5A, 3'b001, 1'b1, 1'b0, 1'b1, 1'b0);
         drv(8'h00, 3'b001, 1'b1, 1'b1, 1'b0, 1'b0);
         cur_tag = "R7";
         drv(8'h77, 3'(p), 1'b0, 1'b1, 1'b0, 1'b0);
         drv(8'h00, 3'b001, 1'b1, 1'b1, 1'b0, 1'b0);
         drv(8'h00, 3'b001, 1'b1, 1'b1, 1'b0, 1'b0);
      end

      // R8: output enable acts only after an edge
      cur_tag = "R8";
      drv(8'h08, 3'b001, 1'b1, 1'b0, 1'b1, 1'b1);
      drv(8'h00, 3'b001, 1'b1, 1'b1, 1'b1, 1'b1);
      drv(8'h00, 3'b001, 1'b1, 1'b1, 1'b1, 1'b0);
      drv(8'h00, 3'b001, 1'b1, 1'b1, 1'b0, 1'b1);
      drv(8'h00, 3'b001, 1'b1, 1'b1, 1'b0, 1'b0);

      // R11: write controls block the driver and leave contents alone
      cur_tag = "R11";
      @(negedge clk); gw_n = 1'b0;
      @(negedge clk); gw_n = 1'b1; bw_n = NB'(1);
      @(negedge clk); bw_n = '1;
      drv(8'h08, 3'b001, 1'b1, 1'b0, 1'b1, 1'b0);
      drv(8'h00, 3'b001, 1'b1, 1'b1, 1'b1, 1'b0);
      drv(8'h00, 3'b001, 1'b1, 1'b1, 1'b1, 1'b0);

      // random mix, R10 on data
      cur_tag = "R10";
      for (int i = 0; i < 3000; i++) begin
         logic [2:0] ce;
         logic sp, sc;
         ce = ($urandom % 6 == 0) ? 3'($urandom) : 3'b001;
         sp = ($urandom % 7 != 0);
         sc = ($urandom % 7 != 0);
         drv(AW'($urandom), ce, sp, sc, 1'($urandom), ($urandom % 8 == 0));
      end
      drv(8'h00, 3'b001, 1'b1, 1'b1, 1'b1, 1'b1);
      @(negedge clk);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      bad++;
      total++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule